// File: doc/BRIEF.md
# DDR Memory Power-Up Sequencer

This block brings a set of DDR memory ranks from power-up to normal operation. A single start pulse launches a fixed series of commands. Each command code is placed on a 3-bit output, and the command is then broadcast to every populated rank. Each broadcast is a dummy read whose address selects the rank and, for the mode-set commands, carries the mode word. The memory controller turns these reads into the matching DRAM command.

Ranks are described by a table of eight cumulative upper limits, each a count of 32 MB units. An entry whose limit is above the running base is a populated rank. A programmable pause separates consecutive commands. After the last mode set, the sequencer switches the command code to normal operation and raises a completion flag that stays high.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset `cmd_code` is 0 (self-refresh code), `rd_req` is low and `init_done` is low.
- R2: The broadcasts carry, in order, the command codes NOP (1), precharge (2), extended mode set (4), mode set (3), precharge (2), auto-refresh (6) eight times, and mode set (3). The code is then switched to normal (7).
- R3: The mode word is placed on the read address with word bit 11 on address bit 13 and word bits 9:0 on address bits 12:3. Address bits 2:0 are zero on every access. The extended mode set uses word 0x000 (DLL on). The first mode set uses 0x16A (burst 4, interleaved, CAS 2.5, DLL reset), giving offset 0xB50. The final mode set uses 0x06A, giving offset 0x350. All other commands use offset 0.
- R4: For each command the limit entries are visited in order 0 to 7, with entry i at `rank_limits[8*i+7:8*i]`. A running base starts at 0. An access is made only when the entry exceeds the base, at address (base << 25) + offset. The base then takes the value of that entry.
- R5: A read request holds its address and command code steady until `rd_ack` is high. After it is acknowledged the request drops for at least one cycle.
- R6: The normal-mode code produces no access, and `cmd_code` stays 7 once the sequence has finished.
- R7: The first access of a command comes at least `wait_cycles` cycles after the last acknowledged access of the previous command. No request is made during a pause.
- R8: `init_done` rises once the sequence ends and stays high until the next start.
- R9: A start pulse while a sequence is running is ignored. A start pulse after completion clears `init_done` and runs the sequence again.
- R10: With every limit at 0 no access is made, and the sequence still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins the power-up sequence |
| wait_cycles | input | WAIT_W (20) | Pause in cycles after each command |
| rank_limits | input | RANKS*BOUND_W (64) | Cumulative upper limits of the ranks, in 32 MB units |
| rd_ack | input | 1 | Acknowledge of the current dummy read |
| cmd_code | output | 3 | Command code presented to the controller |
| rd_req | output | 1 | Dummy read request |
| rd_addr | output | ADDR_W (32) | Dummy read address |
| init_done | output | 1 | Sequence complete |

## Verification
The assertions check, on every cycle, the properties that hold in any single cycle or between neighbouring cycles. A waiting request keeps its address and code, and it drops after an acknowledge. No request appears under the normal code or during a pause. Address bits 2:0 stay clear, the running base never moves down within a walk, and the completion flag stays high. The order of the fourteen commands, the address produced for each rank from a given limit table, and the per-command access count can only be shown by the bench's scenarios. The same holds for the minimum spacing between commands and for ignored and accepted start pulses. These scenarios cover a single rank, ranks with repeated and falling limits, a full table and an empty table.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_SELF_REF     = 3'd0,
    CMD_NOP          = 3'd1,
    CMD_PRECHARGE    = 3'd2,
    CMD_MODE_SET     = 3'd3,
    CMD_EXT_MODE_SET = 3'd4,
    CMD_AUTO_REF     = 3'd6,
    CMD_NORMAL       = 3'd7
  } dram_cmd_e;

  localparam int          NUM_STEPS   = 15;
  localparam int          STEP_W      = 4;
  localparam logic [11:0] MODE_OPER   = 12'h06A; // burst 4, interleaved, CAS 2.5
  localparam logic [11:0] MODE_DLLRST = 12'h100;
  localparam logic [11:0] EXT_DLL_ON  = 12'h000;

  function automatic dram_cmd_e step_cmd(input logic [STEP_W-1:0] s);
    case (s)
      4'd0:    return CMD_NOP;
      4'd1:    return CMD_PRECHARGE;
      4'd2:    return CMD_EXT_MODE_SET;
      4'd3:    return CMD_MODE_SET;
      4'd4:    return CMD_PRECHARGE;
      4'd13:   return CMD_MODE_SET;
      4'd14:   return CMD_NORMAL;
      default: return CMD_AUTO_REF;
    endcase
  endfunction

  function automatic logic [11:0] step_word(input logic [STEP_W-1:0] s);
    case (s)
      4'd2:    return EXT_DLL_ON;
      4'd3:    return MODE_OPER | MODE_DLLRST;
      4'd13:   return MODE_OPER;
      default: return 12'h000;
    endcase
  endfunction

  // word bit 11 -> address bit 13, word bits 9:0 -> address bits 12:3
  function automatic logic [13:0] remap_word(input logic [11:0] w);
    return {w[11], w[9:0], 3'b000};
  endfunction

endpackage

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int WAIT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] cycles,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= cycles;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rank_walker.sv
module rank_walker #(
  parameter int RANKS   = 8,
  parameter int BOUND_W = 8,
  parameter int ADDR_W  = 32,
  parameter int SHIFT   = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [ADDR_W-1:0]        offset,
  input  logic [RANKS*BOUND_W-1:0] limits,
  input  logic                     rd_ack,
  output logic                     rd_req,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     busy,
  output logic                     done
);
  localparam int IDX_W = (RANKS > 1) ? $clog2(RANKS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RANKS - 1);

  typedef enum logic [1:0] {W_IDLE, W_SCAN, W_REQ} walk_st_e;

  logic [BOUND_W-1:0] lim [RANKS];
  for (genvar g = 0; g < RANKS; g++) begin : g_unpack
    assign lim[g] = limits[g*BOUND_W +: BOUND_W];
  end

  walk_st_e           st;
  logic [IDX_W-1:0]   idx;
  logic [BOUND_W-1:0] base;
  logic [BOUND_W-1:0] lim_sel;
  logic               last;

  function automatic logic [ADDR_W-1:0] rank_addr(input logic [BOUND_W-1:0] b,
                                                  input logic [ADDR_W-1:0] off);
    return (ADDR_W'(b) << SHIFT) + off;
  endfunction

  assign lim_sel = lim[idx];
  assign last    = (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      idx     <= '0;
      base    <= '0;
      rd_addr <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        W_IDLE: if (go) begin
          idx  <= '0;
          base <= '0;
          st   <= W_SCAN;
        end
        W_SCAN: if (lim_sel > base) begin
          rd_addr <= rank_addr(base, offset);
          st      <= W_REQ;
        end else if (last) begin
          done <= 1'b1;
          st   <= W_IDLE;
        end else begin
          idx <= idx + 1'b1;
        end
        W_REQ: if (rd_ack) begin
          base <= lim_sel;
          if (last) begin
            done <= 1'b1;
            st   <= W_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= W_SCAN;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign rd_req = (st == W_REQ);
  assign busy   = (st != W_IDLE);

  a_r4_base_rises: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> base >= $past(base));
  a_r5_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int RANKS   = 8,
  parameter int BOUND_W = 8,
  parameter int ADDR_W  = 32,
  parameter int WAIT_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [WAIT_W-1:0]        wait_cycles,
  input  logic [RANKS*BOUND_W-1:0] rank_limits,
  input  logic                     rd_ack,
  output logic [2:0]               cmd_code,
  output logic                     rd_req,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     init_done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_BCAST, T_PAUSE} top_st_e;

  top_st_e           st;
  logic [STEP_W-1:0] step;
  dram_cmd_e         cmd_q;
  dram_cmd_e         cur_cmd;
  logic [ADDR_W-1:0] cur_off;
  logic              walk_go, walk_done, walk_busy;
  logic              timer_load, timer_expired;

  assign cur_cmd    = step_cmd(step);
  assign cur_off    = ADDR_W'(remap_word(step_word(step)));
  assign walk_go    = (st == T_ISSUE) && (cur_cmd != CMD_NORMAL);
  assign timer_load = ((st == T_ISSUE) && (cur_cmd == CMD_NORMAL)) ||
                      ((st == T_BCAST) && walk_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= T_IDLE;
      step      <= '0;
      cmd_q     <= CMD_SELF_REF;
      init_done <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (start) begin
          step      <= '0;
          init_done <= 1'b0;
          st        <= T_ISSUE;
        end
        T_ISSUE: begin
          cmd_q <= cur_cmd;
          st    <= (cur_cmd == CMD_NORMAL) ? T_PAUSE : T_BCAST;
        end
        T_BCAST: if (walk_done) st <= T_PAUSE;
        T_PAUSE: if (timer_expired) begin
          if (step == LAST_STEP) begin
            init_done <= 1'b1;
            st        <= T_IDLE;
          end else begin
            step <= step + 1'b1;
            st   <= T_ISSUE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign cmd_code = cmd_q;

  rank_walker #(
    .RANKS(RANKS), .BOUND_W(BOUND_W), .ADDR_W(ADDR_W), .SHIFT(25)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .go(walk_go), .offset(cur_off),
    .limits(rank_limits), .rd_ack(rd_ack), .rd_req(rd_req),
    .rd_addr(rd_addr), .busy(walk_busy), .done(walk_done)
  );

  wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(timer_load),
    .cycles(wait_cycles), .expired(timer_expired)
  );

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr) && $stable(cmd_code));
  a_r6_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 3'd7 |-> !rd_req);
  a_r3_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[2:0] == 3'b000);
  a_r7_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == T_PAUSE |-> !rd_req && !walk_busy);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done && !start |=> init_done);
endmodule

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] wait_cycles = '0;
  logic [63:0] rank_limits = '0;
  logic        rd_ack = 1'b0;
  logic [2:0]  cmd_code;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        init_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_acc  = 0;
  int          acc_cyc  [0:255];
  logic [2:0]  acc_cmd  [0:255];
  logic [31:0] acc_addr [0:255];

  ddr_init_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_cycles(wait_cycles),
    .rank_limits(rank_limits), .rd_ack(rd_ack), .cmd_code(cmd_code),
    .rd_req(rd_req), .rd_addr(rd_addr), .init_done(init_done)
  );

  initial forever #2.5 clk = ~clk;

  // memory side: acknowledge each request on its third low phase, log it
  initial begin
    int pend;
    pend = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_req) begin
        if (pend == 2) begin
          rd_ack = 1'b1;
          if (n_acc < 256) begin
            acc_cyc[n_acc]  = cyc;
            acc_cmd[n_acc]  = cmd_code;
            acc_addr[n_acc] = rd_addr;
          end
          n_acc++;
          pend = 0;
        end else begin
          rd_ack = 1'b0;
          pend++;
        end
      end else begin
        rd_ack = 1'b0;
        pend = 0;
      end
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cmd(input int s);
    if (s == 0) return 3'd1;
    if (s == 1 || s == 4) return 3'd2;
    if (s == 2) return 3'd4;
    if (s == 3 || s == 13) return 3'd3;
    return 3'd6;
  endfunction

  function automatic logic [31:0] host_off(input logic [11:0] w);
    return (32'(w[11]) << 13) | (32'(w & 12'h3FF) << 3);
  endfunction

  function automatic logic [31:0] exp_off(input int s);
    if (s == 3)  return host_off(12'h16A);
    if (s == 13) return host_off(12'h06A);
    return 32'h0;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    while (!init_done && t < 40000) begin @(negedge clk); t++; end
    check(init_done, "R8", {tag, " completion flag"}, init_done, 1);
  endtask

  task automatic run_case(input logic [63:0] lim, input int w, input string tag,
                          input bit mid_start);
    logic [31:0] bases [0:7];
    int k, bad_cmd, bad_addr, min_gap, t;
    logic [7:0] prev;
    n_acc = 0;
    rank_limits = lim;
    wait_cycles = 20'(w);
    pulse_start();
    if (mid_start) begin
      t = 0;
      while (n_acc < 2 && t < 5000) begin @(negedge clk); t++; end
      pulse_start();
    end
    wait_done(tag);
    // reference walk over the table
    k = 0; prev = 8'd0;
    for (int i = 0; i < 8; i++) begin
      if (lim[i*8 +: 8] > prev) begin
        bases[k] = 32'(prev) << 25;
        k++;
        prev = lim[i*8 +: 8];
      end
    end
    check(cmd_code == 3'd7, "R6", {tag, " code after finish"}, cmd_code, 7);
    check(n_acc == 14*k, mid_start ? "R9" : "R4", {tag, " access count"}, n_acc, 14*k);
    bad_cmd = 0; bad_addr = 0;
    if (n_acc == 14*k) begin
      for (int s = 0; s < 14; s++)
        for (int j = 0; j < k; j++) begin
          if (acc_cmd[s*k+j] !== exp_cmd(s)) bad_cmd++;
          if (acc_addr[s*k+j] !== bases[j] + exp_off(s)) bad_addr++;
        end
    end
    check(bad_cmd == 0, "R2", {tag, " command order mismatches"}, bad_cmd, 0);
    check(bad_addr == 0, "R4", {tag, " address mismatches"}, bad_addr, 0);
    if (k > 0 && n_acc == 14*k) begin
      check(acc_addr[3*k] == 32'hB50 + bases[0], "R3", {tag, " DLL-reset mode offset"},
            acc_addr[3*k], 32'hB50 + bases[0]);
      check(acc_addr[13*k] == 32'h350 + bases[0], "R3", {tag, " final mode offset"},
            acc_addr[13*k], 32'h350 + bases[0]);
      min_gap = 1000000;
      for (int s = 0; s < 13; s++)
        if (acc_cyc[(s+1)*k] - acc_cyc[s*k+k-1] < min_gap)
          min_gap = acc_cyc[(s+1)*k] - acc_cyc[s*k+k-1];
      check(min_gap >= w, "R7", {tag, " smallest gap between commands"}, min_gap, w);
    end
  endtask

  task automatic t_reset();
    check(cmd_code == 3'd0, "R1", "reset code", cmd_code, 0);
    check(rd_req == 1'b0, "R1", "reset request", rd_req, 0);
    check(init_done == 1'b0, "R1", "reset flag", init_done, 0);
  endtask

  task automatic t_single_rank();
    run_case({8{8'h04}}, 5, "single rank", 1'b0);
  endtask

  task automatic t_uneven_ranks();
    // repeated, falling and rising limits
    run_case({8'd9, 8'd9, 8'd0, 8'd7, 8'd6, 8'd6, 8'd2, 8'd2}, 0, "uneven ranks", 1'b0);
  endtask

  task automatic t_full_table();
    run_case({8'd128, 8'd112, 8'd96, 8'd80, 8'd64, 8'd48, 8'd32, 8'd16}, 37, "full table", 1'b0);
  endtask

  task automatic t_empty_table();   // R10
    run_case(64'h0, 3, "R10 empty table", 1'b0);
    check(n_acc == 0, "R10", "accesses with empty table", n_acc, 0);
  endtask

  task automatic t_busy_start();    // R9
    run_case({8{8'h02}}, 4, "start while busy", 1'b1);
  endtask

  task automatic t_restart();
    int still;
    still = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!init_done) still = 0;
    end
    check(still == 1, "R8", "flag held after finish", still, 1);
    check(cmd_code == 3'd7, "R6", "code held after finish", cmd_code, 7);
    pulse_start();
    @(negedge clk);
    check(init_done == 1'b0, "R9", "restart clears flag", init_done, 0);
    wait_done("restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_rank();
    t_uneven_ranks();
    t_full_table();
    t_empty_table();
    t_busy_start();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule